// File: doc/BRIEF.md
# ATA Task-File Register Bank with Upper-Byte Shadows

This block is the host-side copy of the ATA command-block registers for a bus carrying two devices. Software-style accesses arrive as a register index with write data, a write strobe and a read strobe. A separate port writes the device-control register. Every write to a parameter register keeps the value it replaces in a shadow copy. A host can therefore load the upper and lower halves of a 48-bit address or a 16-bit count into the same byte-wide register, one after the other.

Bit 7 of the device-control register picks what readback returns. When it is set, registers that have a shadow return the shadow copy. When it is clear, they return the current value. Any write to a command-block register clears this bit. Because both devices share the bus, each write lands in both devices' copies. Reads come from the copy of the device picked by the stored device/head byte.

A write to the command register gives a one-cycle pulse that carries the command byte, for the command engine downstream. The block holds no data path, status logic or interrupt logic. The status byte is supplied from outside and only passed through on reads.

Top module: `tf_taskfile_bank`

## Requirements
- R1: The register index is the low 3 bits of `addr`; upper address bits have no effect. Index map: 0 data, 1 features, 2 sector count, 3 LBA low, 4 LBA mid, 5 LBA high, 6 device/head, 7 command/status.
- R2: A write to index 1 to 5 copies that register's current value into its shadow and stores `wdata` as the new current value.
- R3: When control bit 7 (mask 0x80) is set, reads of index 1 to 5 return the shadow copy; when it is clear they return the current value. Reads of index 0, 6 and 7 do not depend on this bit.
- R4: A write to any index from 1 to 7 clears control bit 7. If a control write happens in the same cycle, the clear wins. A write to index 0 changes nothing: no register and not the control bit.
- R5: Every command-block write updates both device copies. Bit 4 of the stored device/head byte picks the copy that reads return.
- R6: A write to index 6 stores `wdata | 0xA0`.
- R7: A write to index 7 raises `cmd_pulse` for exactly the following cycle, with `cmd_code` equal to the written byte. Without such a write, `cmd_pulse` stays low.
- R8: After reset, registers 1 to 5 and their shadows read 0x00, device/head reads 0xA0 and control bit 7 is clear.
- R9: A read returns `rdata` with `rvalid` high in the cycle after `rd_en`. The value reflects the state before any write in the same cycle. Index 0 reads 0xFF and index 7 reads `status_in` as sampled with `rd_en`. Reads change no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Access address; only the low 3 bits are decoded |
| wr_en | input | 1 | Command-block write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Command-block read strobe |
| ctl_wr | input | 1 | Device-control register write strobe |
| ctl_wdata | input | 8 | Device-control write data |
| status_in | input | 8 | Status byte returned on index 7 reads |
| rdata | output | 8 | Registered read data |
| rvalid | output | 1 | Read data valid |
| cmd_pulse | output | 1 | One-cycle command issue pulse |
| cmd_code | output | 8 | Command byte issued with the pulse |

## Verification
The bench builds the block with `ADDR_W` set to 5, wider than the default of 3. This puts upper address bits within reach, so accesses that carry non-zero upper bits must still hit the register chosen by the low three bits. The default width only ever presents the decoded bits. The device count and data width are fixed by the bus, so the bench instead covers the orderings that matter. These are a write pair followed by a readback under both select values, the clear caused by every kind of command-block write, a control write colliding with a command-block write, and a device/head write that moves reads to the second device's copy.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
  localparam int TF_DW     = 8;
  localparam int IDX_W     = 3;
  localparam int NUM_DEV   = 2;
  localparam int NUM_PARAM = 5;
  localparam int PSEL_W    = $clog2(NUM_PARAM);

  typedef logic [TF_DW-1:0] tf_byte_t;

  localparam logic [IDX_W-1:0] IDX_DATA  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_FEAT  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_LBAH  = 3'd5;
  localparam logic [IDX_W-1:0] IDX_DEVHD = 3'd6;
  localparam logic [IDX_W-1:0] IDX_CMD   = 3'd7;

  localparam tf_byte_t DEVHD_FORCE = 8'hA0;
  localparam tf_byte_t DEVHD_RST   = 8'hA0;
  localparam tf_byte_t DATA_IDLE   = 8'hFF;
  localparam int       UPPER_BIT   = 7;
  localparam int       DEVSEL_BIT  = 4;
endpackage

// File: rtl/tfr_param_bank.sv
module tfr_param_bank
  import tfr_pkg::*;
#(
  parameter int NPARAM = NUM_PARAM,
  parameter int SEL_W  = PSEL_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [SEL_W-1:0]      sel,
  input  tf_byte_t              wdata,
  output tf_byte_t [NPARAM-1:0] cur_o,
  output tf_byte_t [NPARAM-1:0] shd_o
);
  tf_byte_t [NPARAM-1:0] cur_q;
  tf_byte_t [NPARAM-1:0] shd_q;

  for (genvar p = 0; p < NPARAM; p++) begin : g_reg
    logic hit;
    assign hit = we && (sel == SEL_W'(p));
    always_ff @(posedge clk) begin
      if (rst) begin
        cur_q[p] <= '0;
        shd_q[p] <= '0;
      end else if (hit) begin
        shd_q[p] <= cur_q[p];
        cur_q[p] <= wdata;
      end
    end
  end

  assign cur_o = cur_q;
  assign shd_o = shd_q;
endmodule

// File: rtl/tfr_ctl_reg.sv
module tfr_ctl_reg
  import tfr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ctl_wr,
  input  tf_byte_t ctl_wdata,
  input  logic     cb_wr,
  output logic     upper_sel
);
  tf_byte_t ctl_q;
  tf_byte_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) ctl_d = ctl_wdata;
    if (cb_wr)  ctl_d[UPPER_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_d;
  end

  assign upper_sel = ctl_q[UPPER_BIT];
endmodule

// File: rtl/tfr_read_port.sv
module tfr_read_port
  import tfr_pkg::*;
#(
  parameter int NPARAM = NUM_PARAM
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [IDX_W-1:0]      idx,
  input  logic                  upper_sel,
  input  tf_byte_t [NPARAM-1:0] cur,
  input  tf_byte_t [NPARAM-1:0] shd,
  input  tf_byte_t              devhd,
  input  tf_byte_t              status_in,
  output tf_byte_t              rdata,
  output logic                  rvalid
);
  tf_byte_t mux_d;
  logic [IDX_W-1:0] pidx;

  assign pidx = idx - IDX_FEAT;

  always_comb begin
    if (idx == IDX_DATA)       mux_d = DATA_IDLE;
    else if (idx == IDX_DEVHD) mux_d = devhd;
    else if (idx == IDX_CMD)   mux_d = status_in;
    else if (upper_sel)        mux_d = shd[pidx];
    else                       mux_d = cur[pidx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= mux_d;
    end
  end
endmodule

// File: rtl/tf_taskfile_bank.sv
module tf_taskfile_bank
  import tfr_pkg::*;
#(
  parameter int ADDR_W = IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  input  logic              rd_en,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  input  logic [7:0]        status_in,
  output logic [7:0]        rdata,
  output logic              rvalid,
  output logic              cmd_pulse,
  output logic [7:0]        cmd_code
);
  localparam int DSEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic [IDX_W-1:0]  idx;
  logic              cb_wr;
  logic              param_we;
  logic [PSEL_W-1:0] param_sel;
  logic              devhd_we;
  logic              cmd_we;
  logic              upper_sel;
  logic [DSEL_W-1:0] dev_sel;
  logic [IDX_W-1:0]  param_off;

  tf_byte_t [NUM_DEV-1:0][NUM_PARAM-1:0] cur_all;
  tf_byte_t [NUM_DEV-1:0][NUM_PARAM-1:0] shd_all;
  tf_byte_t [NUM_DEV-1:0]                devhd_q;

  assign idx       = addr[IDX_W-1:0];
  assign cb_wr     = wr_en && (idx != IDX_DATA);
  assign param_we  = wr_en && (idx >= IDX_FEAT) && (idx <= IDX_LBAH);
  assign param_off = idx - IDX_FEAT;
  assign param_sel = param_off[PSEL_W-1:0];
  assign devhd_we  = wr_en && (idx == IDX_DEVHD);
  assign cmd_we    = wr_en && (idx == IDX_CMD);

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    tfr_param_bank #(.NPARAM(NUM_PARAM), .SEL_W(PSEL_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (param_we),
      .sel   (param_sel),
      .wdata (wdata),
      .cur_o (cur_all[d]),
      .shd_o (shd_all[d])
    );

    always_ff @(posedge clk) begin
      if (rst)           devhd_q[d] <= DEVHD_RST;
      else if (devhd_we) devhd_q[d] <= wdata | DEVHD_FORCE;
    end
  end

  assign dev_sel = DSEL_W'(devhd_q[0][DEVSEL_BIT]);

  tfr_ctl_reg u_ctl (
    .clk       (clk),
    .rst       (rst),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .cb_wr     (cb_wr),
    .upper_sel (upper_sel)
  );

  tfr_read_port #(.NPARAM(NUM_PARAM)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .idx       (idx),
    .upper_sel (upper_sel),
    .cur       (cur_all[dev_sel]),
    .shd       (shd_all[dev_sel]),
    .devhd     (devhd_q[dev_sel]),
    .status_in (status_in),
    .rdata     (rdata),
    .rvalid    (rvalid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_pulse <= 1'b0;
      cmd_code  <= '0;
    end else begin
      cmd_pulse <= cmd_we;
      if (cmd_we) cmd_code <= wdata;
    end
  end
endmodule

// File: rtl/tfr_checks.sv
module tfr_checks #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [7:0]        wdata,
  input logic              rd_en,
  input logic              ctl_wr,
  input logic [7:0]        status_in,
  input logic [7:0]        rdata,
  input logic              rvalid,
  input logic              cmd_pulse,
  input logic [7:0]        cmd_code,
  input logic              upper_sel
);
  a_r7_cmd_issue: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[2:0] == 3'd7) |=> (cmd_pulse && cmd_code == $past(wdata)));

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr[2:0] == 3'd7) |=> !cmd_pulse);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);

  a_r9_valid_quiet: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid);

  a_r9_data_idle: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[2:0] == 3'd0) |=> (rdata == 8'hFF));

  a_r9_status_pass: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[2:0] == 3'd7) |=> (rdata == $past(status_in)));

  a_r6_devhd_forced: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[2:0] == 3'd6) |=> (rdata[7] && rdata[5]));

  a_r4_select_cleared: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[2:0] != 3'd0) |=> !upper_sel);

  a_r4_data_write_keeps: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[2:0] == 3'd0 && !ctl_wr) |=> $stable(upper_sel));
endmodule

bind tf_taskfile_bank tfr_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk       (clk),
  .rst       (rst),
  .addr      (addr),
  .wr_en     (wr_en),
  .wdata     (wdata),
  .rd_en     (rd_en),
  .ctl_wr    (ctl_wr),
  .status_in (status_in),
  .rdata     (rdata),
  .rvalid    (rvalid),
  .cmd_pulse (cmd_pulse),
  .cmd_code  (cmd_code),
  .upper_sel (upper_sel)
);

// File: tb/test_tf_taskfile_bank.sv
`timescale 1ns/1ps
module test_tf_taskfile_bank;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    wdata = '0;
  logic          rd_en = 1'b0;
  logic          ctl_wr = 1'b0;
  logic [7:0]    ctl_wdata = '0;
  logic [7:0]    status_in = 8'h5A;
  logic [7:0]    rdata;
  logic          rvalid;
  logic          cmd_pulse;
  logic [7:0]    cmd_code;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  logic [7:0] m_cur [1:5];
  logic [7:0] m_shd [1:5];
  logic [7:0] m_dh;
  logic       m_sel;

  always #2 clk = ~clk;

  tf_taskfile_bank #(.ADDR_W(AW)) i_tf_taskfile_bank (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .status_in(status_in), .rdata(rdata), .rvalid(rvalid),
    .cmd_pulse(cmd_pulse), .cmd_code(cmd_code)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input int idx);
    if (idx == 0) return 8'hFF;
    if (idx == 6) return m_dh;
    if (idx == 7) return status_in;
    return m_sel ? m_shd[idx] : m_cur[idx];
  endfunction

  // Monitor: compares each valid read against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected rvalid", rdata, 8'h00);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata === e, t, rdata, e);
      end
    end
  end

  task automatic do_read(input int idx, input logic [1:0] hi, input string tag);
    addr  = {hi, 3'(idx)};
    rd_en = 1'b1;
    exp_q.push_back(model_read(idx));
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_write(input int idx, input logic [7:0] val, input logic [1:0] hi);
    addr  = {hi, 3'(idx)};
    wdata = val;
    wr_en = 1'b1;
    if (idx >= 1 && idx <= 5) begin
      m_shd[idx] = m_cur[idx];
      m_cur[idx] = val;
    end
    if (idx == 6) m_dh = val | 8'hA0;
    if (idx != 0) m_sel = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx == 7)
      check(cmd_pulse === 1'b1 && cmd_code === val, "R7 command pulse", cmd_code, val);
    else
      check(cmd_pulse === 1'b0, "R7 no pulse", {7'd0, cmd_pulse}, 8'h00);
  endtask

  task automatic do_ctl(input logic [7:0] val);
    ctl_wr    = 1'b1;
    ctl_wdata = val;
    m_sel     = val[7];
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    check(1'b0, "watchdog expired", 8'h00, 8'h00);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 1; i <= 5; i++) begin
      m_cur[i] = 8'h00;
      m_shd[i] = 8'h00;
    end
    m_dh  = 8'hA0;
    m_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8: reset state of every index
    for (int i = 0; i < 8; i++) do_read(i, 2'b00, "R8 reset readback");
    // R8: shadows are zero after reset
    do_ctl(8'h80);
    for (int i = 1; i <= 5; i++) do_read(i, 2'b00, "R8 reset shadow");
    do_ctl(8'h00);

    // R2/R3: write pairs then read current and shadow
    for (int i = 1; i <= 5; i++) begin
      do_write(i, 8'(8'h10 * i + 1), 2'b00);
      do_write(i, 8'(8'h10 * i + 2), 2'b00);
    end
    for (int i = 1; i <= 5; i++) do_read(i, 2'b00, "R2 current after pair");
    do_ctl(8'h80);
    for (int i = 1; i <= 5; i++) do_read(i, 2'b00, "R3 shadow selected");
    do_read(6, 2'b00, "R3 device/head ignores select");
    do_read(0, 2'b00, "R3 data ignores select");
    status_in = 8'h3C;
    do_read(7, 2'b00, "R9 status with select");

    // R4: parameter write clears the select
    do_write(3, 8'h77, 2'b00);
    do_read(1, 2'b00, "R4 cleared by parameter write");
    // R4: command write clears the select; R7 pulse
    do_ctl(8'h80);
    do_write(7, 8'hEC, 2'b00);
    do_read(2, 2'b00, "R4 cleared by command write");
    // R4: device/head write clears the select; R6 forced bits
    do_ctl(8'h80);
    do_write(6, 8'h00, 2'b00);
    do_read(3, 2'b00, "R4 cleared by device/head write");
    do_read(6, 2'b00, "R6 forced bits");
    // R4: data index write changes nothing
    do_ctl(8'h80);
    do_write(0, 8'h99, 2'b00);
    for (int i = 1; i <= 5; i++) do_read(i, 2'b00, "R4 data write ignored");
    // R4: same-cycle control write and command-block write
    ctl_wr = 1'b1;
    ctl_wdata = 8'h80;
    do_write(1, 8'h44, 2'b00);
    ctl_wr = 1'b0;
    do_read(1, 2'b00, "R4 clear wins over control write");
    // R3: control value with bit 7 clear but other bits set
    do_ctl(8'h7F);
    do_read(1, 2'b00, "R3 other control bits no effect");

    // R1: upper address bits ignored
    do_write(2, 8'hC3, 2'b11);
    do_read(2, 2'b10, "R1 upper address bits ignored");
    do_read(2, 2'b00, "R1 decoded index");

    // R5/R6: select device 1, copies equal
    do_write(6, 8'h10, 2'b01);
    do_read(6, 2'b00, "R5 device 1 head");
    for (int i = 1; i <= 5; i++) do_read(i, 2'b00, "R5 device 1 copy");
    do_ctl(8'h80);
    for (int i = 1; i <= 5; i++) do_read(i, 2'b00, "R5 device 1 shadow");

    // R9: repeated reads have no side effects
    do_read(4, 2'b00, "R9 read repeat first");
    do_read(4, 2'b00, "R9 read repeat second");

    // R9: read and write same cycle returns old value
    addr = 5'(3'd5);
    rd_en = 1'b1;
    wr_en = 1'b1;
    wdata = 8'hAB;
    exp_q.push_back(model_read(5));
    tag_q.push_back("R9 read before same-cycle write");
    m_shd[5] = m_cur[5];
    m_cur[5] = 8'hAB;
    m_sel = 1'b0;
    @(negedge clk);
    rd_en = 1'b0;
    wr_en = 1'b0;
    do_read(5, 2'b00, "R9 value after same-cycle write");

    // R7: second command byte
    do_write(7, 8'h24, 2'b10);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9 all reads answered", 8'(exp_q.size()), 8'h00);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule